// File: doc/BRIEF.md
# Video Line Timing and Sync Word Tracker

This block watches a 10-bit parallel digital video word stream and finds the timing reference sequences embedded in it. A sequence is three words, all-ones, all-zeros and all-zeros, followed by one identification word. From these sequences and their identification words the block derives a line sync indication, a vertical blanking indication, a three-bit field number and a flag that reports a stream which has lost its timing references. It also finds ancillary data packets and raises a marker across each of them. The words pass through unchanged. Every indication is registered and lined up with the output word it describes, so logic further down the chain can use the data and the indications together.

The video standard comes in on inputs. One input selects component (4:2:2) or composite (4fsc) behaviour, and one selects the 8-field or the 4-field colour sequence for composite. A third input extends the ancillary marker so that it also covers the timing reference blocks. The block uses a six-word look-ahead window, so an ancillary packet can be sized from its length word before the packet's first word leaves. The delay from input to output is seven clocks.

Top module: `vtrs_tracker`

## Requirements
- R1: `dout` equals `din` delayed by exactly 7 clock cycles, and every indication output describes the word on `dout` in the same cycle.
- R2: In component mode (`composite_mode`=0) a sync block is all-ones, zero, zero, then an ID word in which bit 6 is 1 for an end-of-line block and 0 for a start-of-line block. `hsync` goes high on the first word of an end-of-line block. It stays high through the last word of the next start-of-line block and is low on the word after that.
- R3: In composite mode (`composite_mode`=1) `hsync` is high for exactly one cycle, on the all-ones word of each sync block, and low otherwise.
- R4: In component mode `vblank` takes ID bit 7 and `field_id` takes {0,0,ID bit 8}, updated on the first word of each end-of-line block. Start-of-line blocks leave both unchanged.
- R5: In composite mode, on the first word of each sync block, `vblank` becomes 1 exactly when the line code in ID bits 7:3 is between 1 and VB_LAST_LINE (default 20). `field_id` becomes ID bits 2:0 when `pal_mode`=1 and {0, ID bits 1:0} when `pal_mode`=0.
- R6: `anc_flag` is high from the first word of an ancillary header (000h, 3FFh, 3FFh) through the packet's checksum word. The packet spans DC+7 words, where DC is bits 7:0 of the sixth packet word (header, type ID, block number, count, DC data words, checksum). A header seen inside a running packet is not taken as a new packet.
- R7: With `trs_mark_en`=1, `anc_flag` is also high on the 4 words of each component sync block and on the 5 words starting at each composite all-ones word. With `trs_mark_en`=0, sync blocks do not raise `anc_flag`.
- R8: `no_trs` rises after seven windows of GAP_LIMIT words in a row pass with no sync block. Any sync block restarts that run.
- R9: Once raised, `no_trs` clears only after seven sync blocks in a row with no empty window between them. An empty window restarts the count.
- R10: While reset is applied, `dout`, `hsync`, `vblank`, `field_id`, `anc_flag` and `no_trs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock inside the block |
| din | input | 10 | Incoming video word |
| composite_mode | input | 1 | 1 selects composite behaviour, 0 selects component |
| pal_mode | input | 1 | Composite only: 1 gives eight colour fields, 0 gives four |
| trs_mark_en | input | 1 | 1 makes the ancillary marker also cover sync blocks |
| dout | output | 10 | Outgoing video word, 7 clocks after input |
| hsync | output | 1 | Line sync indication |
| vblank | output | 1 | Vertical blanking indication |
| field_id | output | 3 | Field or colour field number |
| anc_flag | output | 1 | Ancillary packet (and optionally sync block) marker |
| no_trs | output | 1 | Loss of timing reference flag |

## Verification
The ancillary marker and the line sync can be high on the same output words. So can the ancillary marker from a packet and the one from a sync block. To provoke both overlaps, the stimulus places ancillary packets straight after end-of-line blocks while sync marking is on, and straight after a composite sync block's five-word span. A scoreboard then judges every output word on its own data, sync, blanking, field and marker values, so a gap or an extra cycle anywhere along the joined spans shows up on the word where it occurs. The loss flag is checked on both sides of its seven-window threshold, and again after a single sync block or a single empty window has broken a run.

// File: rtl/vtrs_pkg.sv
package vtrs_pkg;
  localparam int WORD_W        = 10;
  localparam int FIELD_W       = 3;
  localparam int WIN_LEN       = 6;
  localparam int COMP_BLK_LEN  = 4;
  localparam int CPST_BLK_LEN  = 5;
  localparam int ANC_OVERHEAD  = 7;
  localparam int DC_BITS       = 8;
  localparam int XYZ_H_BIT     = 6;
  localparam int XYZ_V_BIT     = 7;
  localparam int XYZ_F_BIT     = 8;
  localparam int LINE_LSB      = 3;
  localparam int LINE_MSB      = 7;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t WORD_ONES = '1;
  localparam word_t WORD_ZERO = '0;
endpackage

// File: rtl/vtrs_word_window.sv
module vtrs_word_window
  import vtrs_pkg::*;
#(
  parameter int DEPTH = WIN_LEN
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t din,
  output word_t taps [DEPTH]
);
  word_t stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    word_t stage_d;
    if (g == 0) begin : g_head
      assign stage_d = din;
    end else begin : g_body
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= WORD_ZERO;
      else        stage_q[g] <= stage_d;
    end

    assign taps[g] = stage_q[g];
  end
endmodule

// File: rtl/vtrs_sync_tracker.sv
module vtrs_sync_tracker
  import vtrs_pkg::*;
#(
  parameter int VB_LAST_LINE = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  word_t              w_lead,
  input  word_t              w_zero_a,
  input  word_t              w_zero_b,
  input  word_t              w_id,
  input  logic               composite_mode,
  input  logic               pal_mode,
  output logic               trs_hit,
  output logic               in_block,
  output logic               hsync_q,
  output logic               vblank_q,
  output logic [FIELD_W-1:0] field_q
);
  localparam int BLK_W = $clog2(CPST_BLK_LEN);

  logic [BLK_W-1:0]   blk_rem_q, blk_rem_d;
  logic               sav_blk_q, sav_blk_d;
  logic               line_hi_q, line_hi_d;
  logic               hsync_d, vblank_d;
  logic [FIELD_W-1:0] field_d;
  logic               is_eav, line_in_vbi;
  logic [LINE_MSB-LINE_LSB:0] line_code;

  always_comb begin
    trs_hit     = (w_lead == WORD_ONES) && (w_zero_a == WORD_ZERO) && (w_zero_b == WORD_ZERO);
    is_eav      = w_id[XYZ_H_BIT];
    line_code   = w_id[LINE_MSB:LINE_LSB];
    line_in_vbi = (line_code != '0) && (int'(line_code) <= VB_LAST_LINE);
    in_block    = trs_hit || (blk_rem_q != '0);

    blk_rem_d = blk_rem_q;
    sav_blk_d = sav_blk_q;
    line_hi_d = line_hi_q;
    vblank_d  = vblank_q;
    field_d   = field_q;

    if (trs_hit) begin
      blk_rem_d = composite_mode ? BLK_W'(CPST_BLK_LEN - 1) : BLK_W'(COMP_BLK_LEN - 1);
      sav_blk_d = !is_eav;
      line_hi_d = is_eav;
    end else if (blk_rem_q != '0) begin
      blk_rem_d = blk_rem_q - 1'b1;
    end

    if (composite_mode) begin
      hsync_d = trs_hit;
      if (trs_hit) begin
        vblank_d = line_in_vbi;
        field_d  = pal_mode ? w_id[FIELD_W-1:0] : {1'b0, w_id[FIELD_W-2:0]};
      end
    end else begin
      hsync_d = trs_hit || line_hi_q || ((blk_rem_q != '0) && sav_blk_q);
      if (trs_hit && is_eav) begin
        vblank_d = w_id[XYZ_V_BIT];
        field_d  = {{(FIELD_W-1){1'b0}}, w_id[XYZ_F_BIT]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_rem_q <= '0;
      sav_blk_q <= 1'b0;
      line_hi_q <= 1'b0;
      hsync_q   <= 1'b0;
      vblank_q  <= 1'b0;
      field_q   <= '0;
    end else begin
      blk_rem_q <= blk_rem_d;
      sav_blk_q <= sav_blk_d;
      line_hi_q <= line_hi_d;
      hsync_q   <= hsync_d;
      vblank_q  <= vblank_d;
      field_q   <= field_d;
    end
  end

  // R3: a composite sync pulse never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_q && $past(composite_mode)) |=> (!hsync_q || !$past(composite_mode)));

  // R7: a marked sync block never outlasts the longer block length
  a_r7_block_bound: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rem_q <= BLK_W'(CPST_BLK_LEN - 1));
endmodule

// File: rtl/vtrs_anc_tracker.sv
module vtrs_anc_tracker
  import vtrs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t w_hdr0,
  input  word_t w_hdr1,
  input  word_t w_hdr2,
  input  word_t w_count,
  output logic  anc_now
);
  localparam int MAX_SPAN = (1 << DC_BITS) - 1 + ANC_OVERHEAD;
  localparam int REM_W    = $clog2(MAX_SPAN);

  logic [REM_W-1:0] anc_rem_q, anc_rem_d;
  logic             hdr_start;

  always_comb begin
    hdr_start = (anc_rem_q == '0) && (w_hdr0 == WORD_ZERO) &&
                (w_hdr1 == WORD_ONES) && (w_hdr2 == WORD_ONES);
    anc_now   = hdr_start || (anc_rem_q != '0);
    anc_rem_d = anc_rem_q;
    if (hdr_start)
      anc_rem_d = REM_W'(w_count[DC_BITS-1:0]) + REM_W'(ANC_OVERHEAD - 1);
    else if (anc_rem_q != '0)
      anc_rem_d = anc_rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) anc_rem_q <= '0;
    else        anc_rem_q <= anc_rem_d;
  end

  // R6: the remaining span never exceeds the longest packet
  a_r6_span_bound: assert property (@(posedge clk) disable iff (!rst_n)
    anc_rem_q <= REM_W'(MAX_SPAN - 1));

  // R6: a running packet keeps the marker up on the next word
  a_r6_span_cont: assert property (@(posedge clk) disable iff (!rst_n)
    (anc_rem_q > REM_W'(1)) |=> anc_now);
endmodule

// File: rtl/vtrs_loss_monitor.sv
module vtrs_loss_monitor #(
  parameter int GAP_LIMIT = 1800,
  parameter int RUN_LEN   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trs_hit,
  output logic no_trs_q
);
  localparam int GAP_W = $clog2(GAP_LIMIT);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [RUN_W-1:0] miss_q, miss_d, hit_q, hit_d;
  logic             no_trs_d, window_miss;

  always_comb begin
    window_miss = !trs_hit && (gap_q == GAP_W'(GAP_LIMIT - 1));
    gap_d    = (trs_hit || window_miss) ? '0 : gap_q + 1'b1;
    miss_d   = miss_q;
    hit_d    = hit_q;
    no_trs_d = no_trs_q;
    if (trs_hit) begin
      miss_d = '0;
      if (hit_q != RUN_W'(RUN_LEN)) hit_d = hit_q + 1'b1;
      if (hit_q == RUN_W'(RUN_LEN - 1)) no_trs_d = 1'b0;
    end else if (window_miss) begin
      hit_d = '0;
      if (miss_q != RUN_W'(RUN_LEN)) miss_d = miss_q + 1'b1;
      if (miss_q == RUN_W'(RUN_LEN - 1)) no_trs_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      miss_q   <= '0;
      hit_q    <= '0;
      no_trs_q <= 1'b0;
    end else begin
      gap_q    <= gap_d;
      miss_q   <= miss_d;
      hit_q    <= hit_d;
      no_trs_q <= no_trs_d;
    end
  end

  // R8: the flag rises only at the seventh empty window in a row
  a_r8_rise_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_trs_q) |-> ($past(miss_q) == RUN_W'(RUN_LEN - 1)));

  // R9: the flag falls only at the seventh sync block in a row
  a_r9_fall_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_trs_q) |-> ($past(hit_q) == RUN_W'(RUN_LEN - 1)));
endmodule

// File: rtl/vtrs_tracker.sv
module vtrs_tracker
  import vtrs_pkg::*;
#(
  parameter int GAP_LIMIT    = 1800,
  parameter int RUN_LEN      = 7,
  parameter int VB_LAST_LINE = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  din,
  input  logic               composite_mode,
  input  logic               pal_mode,
  input  logic               trs_mark_en,
  output logic [WORD_W-1:0]  dout,
  output logic               hsync,
  output logic               vblank,
  output logic [FIELD_W-1:0] field_id,
  output logic               anc_flag,
  output logic               no_trs
);
  localparam int LATENCY = WIN_LEN + 1;
  localparam int LAT_W   = $clog2(LATENCY + 1);

  logic       rst_meta, rst_sync_n;
  word_t      taps [WIN_LEN];
  logic       trs_hit, in_block, anc_now;
  word_t      dout_q;
  logic       anc_q;
  logic [LAT_W-1:0] lat_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  vtrs_word_window #(.DEPTH(WIN_LEN)) u_window (
    .clk(clk), .rst_n(rst_sync_n), .din(din), .taps(taps)
  );

  vtrs_sync_tracker #(.VB_LAST_LINE(VB_LAST_LINE)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .w_lead(taps[WIN_LEN-1]), .w_zero_a(taps[WIN_LEN-2]),
    .w_zero_b(taps[WIN_LEN-3]), .w_id(taps[WIN_LEN-4]),
    .composite_mode(composite_mode), .pal_mode(pal_mode),
    .trs_hit(trs_hit), .in_block(in_block),
    .hsync_q(hsync), .vblank_q(vblank), .field_q(field_id)
  );

  vtrs_anc_tracker u_anc (
    .clk(clk), .rst_n(rst_sync_n),
    .w_hdr0(taps[WIN_LEN-1]), .w_hdr1(taps[WIN_LEN-2]),
    .w_hdr2(taps[WIN_LEN-3]), .w_count(taps[0]),
    .anc_now(anc_now)
  );

  vtrs_loss_monitor #(.GAP_LIMIT(GAP_LIMIT), .RUN_LEN(RUN_LEN)) u_loss (
    .clk(clk), .rst_n(rst_sync_n), .trs_hit(trs_hit), .no_trs_q(no_trs)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout_q     <= WORD_ZERO;
      anc_q      <= 1'b0;
      lat_seen_q <= '0;
    end else begin
      dout_q <= taps[WIN_LEN-1];
      anc_q  <= anc_now || (trs_mark_en && in_block);
      if (lat_seen_q != LAT_W'(LATENCY)) lat_seen_q <= lat_seen_q + 1'b1;
    end
  end

  assign dout     = dout_q;
  assign anc_flag = anc_q;

  // R1: output word is the input word from exactly LATENCY clocks before
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lat_seen_q == LAT_W'(LATENCY)) |-> (dout == $past(din, LATENCY)));

  // R10: reset clears the indications
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (!hsync && !anc_flag && !no_trs && dout == WORD_ZERO));
endmodule

// File: tb/tb_vtrs_tracker.sv
module tb_vtrs_tracker;
  localparam int LAT = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] din;
  logic       composite_mode, pal_mode, trs_mark_en;
  logic [9:0] dout;
  logic       hsync, vblank, anc_flag, no_trs;
  logic [2:0] field_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [9:0] w;
    logic       hs;
    logic       vb;
    logic [2:0] fld;
    logic       anc;
    logic       cpst;
    logic       blk;
  } exp_t;

  exp_t sb[$];
  logic       m_vb = 1'b0;
  logic [2:0] m_fld = 3'd0;
  logic       m_hs_level = 1'b0;

  always #2.5 clk = ~clk;

  vtrs_tracker #(.GAP_LIMIT(100)) dut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .composite_mode(composite_mode), .pal_mode(pal_mode), .trs_mark_en(trs_mark_en),
    .dout(dout), .hsync(hsync), .vblank(vblank), .field_id(field_id),
    .anc_flag(anc_flag), .no_trs(no_trs)
  );

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic put(input logic [9:0] w, input logic hs, input logic anc, input logic blk);
    exp_t e;
    @(negedge clk);
    din = w;
    e.w = w; e.hs = hs; e.vb = m_vb; e.fld = m_fld; e.anc = anc;
    e.cpst = composite_mode; e.blk = blk;
    sb.push_back(e);
  endtask

  function automatic logic idle_hs();
    return composite_mode ? 1'b0 : m_hs_level;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(10'h080 | 10'(i % 64), idle_hs(), 1'b0, 1'b0);
  endtask

  // component sync block: bit 9 set, bit 8 field, bit 7 blanking, bit 6 end-of-line
  task automatic comp_trs(input logic eol, input logic f, input logic v);
    logic [9:0] xyz;
    xyz = {1'b1, f, v, eol, 6'h00};
    if (eol) begin
      m_vb = v; m_fld = {2'b00, f}; m_hs_level = 1'b1;
    end
    put(10'h3FF, 1'b1, trs_mark_en, 1'b1);
    put(10'h000, 1'b1, trs_mark_en, 1'b1);
    put(10'h000, 1'b1, trs_mark_en, 1'b1);
    put(xyz,     1'b1, trs_mark_en, 1'b1);
    if (!eol) m_hs_level = 1'b0;
  endtask

  // composite sync block: ID bits 7:3 line code, bits 2:0 colour field
  task automatic cpst_trs(input logic [4:0] line, input logic [2:0] f);
    logic [9:0] id;
    id = {2'b10, line, f};
    m_vb  = (line != 5'd0) && (line <= 5'd20);
    m_fld = pal_mode ? f : {1'b0, f[1:0]};
    put(10'h3FF, 1'b1, trs_mark_en, 1'b1);
    put(10'h000, 1'b0, trs_mark_en, 1'b1);
    put(10'h000, 1'b0, trs_mark_en, 1'b1);
    put(id,      1'b0, trs_mark_en, 1'b1);
    put(10'h155, 1'b0, trs_mark_en, 1'b1);
  endtask

  task automatic anc_pkt(input int n);
    logic h;
    h = idle_hs();
    put(10'h000, h, 1'b1, 1'b0);
    put(10'h3FF, h, 1'b1, 1'b0);
    put(10'h3FF, h, 1'b1, 1'b0);
    put(10'h1F0, h, 1'b1, 1'b0);
    put(10'h200, h, 1'b1, 1'b0);
    put({2'b01, 8'(n)}, h, 1'b1, 1'b0);
    for (int i = 0; i < n; i++) put(10'h140 + 10'(i), h, 1'b1, 1'b0);
    put(10'h1A5, h, 1'b1, 1'b0);
  endtask

  // scoreboard monitor: one expected item per output word, 7 words behind the driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() >= LAT) begin
        exp_t e;
        e = sb.pop_front();
        chk("R1", "dout", 16'(dout), 16'(e.w));
        chk(e.cpst ? "R3" : "R2", "hsync", 16'(hsync), 16'(e.hs));
        chk(e.cpst ? "R5" : "R4", "vblank", 16'(vblank), 16'(e.vb));
        chk(e.cpst ? "R5" : "R4", "field_id", 16'(field_id), 16'(e.fld));
        chk(e.blk ? "R7" : "R6", "anc_flag", 16'(anc_flag), 16'(e.anc));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; din = 10'h040;
    composite_mode = 1'b0; pal_mode = 1'b0; trs_mark_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "dout", 16'(dout), 16'h0);
    chk("R10", "hsync", 16'(hsync), 16'h0);
    chk("R10", "vblank", 16'(vblank), 16'h0);
    chk("R10", "field_id", 16'(field_id), 16'h0);
    chk("R10", "anc_flag", 16'(anc_flag), 16'h0);
    chk("R10", "no_trs", 16'(no_trs), 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // component lines, marking off; SAV carries opposite F/V to show it is ignored (R4)
    for (int k = 0; k < 6; k++) begin
      comp_trs(1'b1, k >= 3, k < 2);
      if (k % 2 == 0) anc_pkt(3);
      idle(10);
      comp_trs(1'b0, k < 3, k >= 2);
      idle(20);
    end
    chk("R8", "no_trs steady stream", 16'(no_trs), 16'h0);

    // marking on: packets directly after end-of-line blocks overlap with hsync (R6, R7)
    trs_mark_en = 1'b1;
    idle(2);
    for (int k = 0; k < 4; k++) begin
      comp_trs(1'b1, k[0], k[1]);
      anc_pkt(k == 0 ? 0 : (k == 1 ? 20 : 5));
      idle(8);
      comp_trs(1'b0, 1'b0, 1'b0);
      idle(15);
    end
    idle(12);

    // composite, four colour fields then eight
    composite_mode = 1'b1;
    idle(12);
    cpst_trs(5'd3, 3'd6);  anc_pkt(4); idle(20);
    cpst_trs(5'd20, 3'd5); idle(25);
    trs_mark_en = 1'b0;
    idle(10);
    cpst_trs(5'd21, 3'd7); idle(25);
    pal_mode = 1'b1;
    idle(5);
    cpst_trs(5'd31, 3'd6); idle(25);
    cpst_trs(5'd0, 3'd5);  anc_pkt(2); idle(25);
    trs_mark_en = 1'b1;
    idle(10);
    cpst_trs(5'd1, 3'd7);  idle(25);

    // loss of timing reference (R8)
    idle(650);
    chk("R8", "no_trs after six empty windows", 16'(no_trs), 16'h0);
    cpst_trs(5'd31, 3'd1);
    idle(650);
    chk("R8", "no_trs after run broken by one block", 16'(no_trs), 16'h0);
    idle(100);
    chk("R8", "no_trs after seven empty windows", 16'(no_trs), 16'h1);

    // recovery needs seven blocks in a row (R9)
    for (int k = 0; k < 6; k++) begin cpst_trs(5'd31, 3'(k)); idle(25); end
    chk("R9", "no_trs after six blocks", 16'(no_trs), 16'h1);
    idle(150);
    for (int k = 0; k < 6; k++) begin cpst_trs(5'd31, 3'(k)); idle(25); end
    chk("R9", "no_trs after empty window then six blocks", 16'(no_trs), 16'h1);
    cpst_trs(5'd31, 3'd2);
    idle(25);
    chk("R9", "no_trs after seven blocks", 16'(no_trs), 16'h0);

    idle(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule